// File: doc/BRIEF.md
# Dual-Bank Edge Interrupt Controller

This block gathers up to fifty peripheral interrupt lines into one interrupt request for a host processor, plus a separate wake request. Each line passes through a two-flop synchroniser and then an edge detector. A per-line polarity bit selects whether a rising or a falling transition counts. A detected edge sets a sticky status bit. Software reads the status bit and clears it by writing a one. Only status bits whose enable bit is set contribute to the combined request. A second, independent detector per line, with its own polarity and enable, drives the wake request.

Source numbers run from 0 to 54 and are split over two 32-bit banks. Sources 0 to 26 live in bank 0 and sources 32 to 54 in bank 1. Numbers 27 to 31 have no hardware. Every register exists once per bank, and the bank 1 copy sits four bytes above the bank 0 copy. The host detects edges on the combined request. For that reason the block pulls the request low for one cycle after any clear, and raises it again if enabled events are still latched.

Top module: `edge_irq_aggregator`

## Requirements
- R1: Source n below 27 maps to bank 0 bit n, and source n from 32 to 54 maps to bank 1 bit n-32. Inputs 27 to 31 are ignored. Bank 0 bits 31:27 and bank 1 bits 31:23 always read 0 and cannot be written.
- R2: Word-aligned byte offsets are used: enable 0x00, polarity 0x08, status 0x10, wake enable 0x18, wake polarity 0x20. Bank 1 sits at offset+4. Any other or misaligned address reads 0 and writes to it change nothing.
- R3: A polarity bit of 0 latches a rising edge and 1 latches a falling edge. A steady level latches nothing.
- R4: Reading status returns the latched events. Writing 1 to a bit clears it, and writing 0 leaves it (and the request) unchanged.
- R5: A write that clears any status bit forces `irq_out` low in the next cycle. The cycle after that, `irq_out` is high again if enabled events remain latched.
- R6: Flipping a polarity bit and restoring it on the next write latches an event on that source when the flip makes the level look like a qualifying edge.
- R7: After reset, all enable, wake-enable, wake-polarity and status bits are 0. Bank 0 polarity is 0, and bank 1 polarity is 0x0006_0000 (sources 49 and 50 falling). Both outputs are low.
- R8: Status bits latch whether or not the source is enabled. `irq_out` is the registered OR over both banks of status AND enable.
- R9: `wake_out` pulses for one cycle when a wake-enabled source shows an edge matching its wake polarity, three cycles after the input changes. It does not depend on the normal enable bits.
- R10: When an edge is detected on a bit in the same cycle as a write of 1 that clears that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 55 | Raw source lines indexed by source number |
| reg_addr | input | 9 | Byte address in the register window |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_out | output | 1 | Combined interrupt request |
| wake_out | output | 1 | Wake request pulse |

## Verification
The bench targets the re-pulse after a partial clear. A design that keeps the request high would leave an edge-sensitive host waiting forever on the events still latched. It lands a clear in the exact cycle a new edge is latched: a design where the clear wins silently loses an interrupt. It also flips and restores a polarity bit with a quiet input, which only latches if the detector compares the polarity-adjusted level against its previous value rather than the raw input. Finally, it checks that sources 49 and 50 come out of reset falling-sensitive without a spurious event, and that pad bits stay zero while their inputs toggle.

// File: rtl/eic_pkg.sv
package eic_pkg;
   typedef enum logic [2:0] {
      RSEL_EN   = 3'd0,
      RSEL_POL  = 3'd1,
      RSEL_STAT = 3'd2,
      RSEL_WEN  = 3'd3,
      RSEL_WPOL = 3'd4
   } rsel_e;

   typedef struct packed {
      logic en;
      logic pol;
      logic stat;
      logic wen;
      logic wpol;
   } bank_we_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (W < 1) begin : g_bad_w
      $error("eic_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
         end else begin
            chain[0] <= din;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
         end
      end
      assign dout = chain[STAGES-1];
   end
endmodule

// File: rtl/eic_bank.sv
module eic_bank
   import eic_pkg::*;
#(
   parameter int                BANK_W  = 32,
   parameter int                USED    = 27,
   parameter logic [BANK_W-1:0] POL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] src_s,
   input  bank_we_t          we,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] en_q,
   output logic [BANK_W-1:0] pol_q,
   output logic [BANK_W-1:0] stat_q,
   output logic [BANK_W-1:0] wen_q,
   output logic [BANK_W-1:0] wpol_q,
   output logic [BANK_W-1:0] edge_ev,
   output logic [BANK_W-1:0] wake_ev,
   output logic [BANK_W-1:0] clr
);
   localparam logic [BANK_W-1:0] USED_MASK = BANK_W'((65'd1 << USED) - 65'd1);
   localparam logic [BANK_W-1:0] LVL_RST   = POL_RST & USED_MASK;

   if (USED < 1 || USED > BANK_W) begin : g_bad_used
      $error("eic_bank: USED out of range");
   end

   logic [BANK_W-1:0] lvl, lvl_q, wlvl, wlvl_q, wmask;

   // Polarity-adjusted level: a qualifying edge is always a 0->1 step here,
   // so a polarity flip alone can create one.
   assign lvl     = (src_s ^ pol_q) & USED_MASK;
   assign wlvl    = (src_s ^ wpol_q) & USED_MASK;
   assign edge_ev = lvl & ~lvl_q;
   assign wake_ev = wlvl & ~wlvl_q & wen_q;
   assign clr     = we.stat ? (wdata & USED_MASK) : '0;
   assign wmask   = wdata & USED_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= POL_RST & USED_MASK;
         stat_q <= '0;
         wen_q  <= '0;
         wpol_q <= '0;
         lvl_q  <= LVL_RST;
         wlvl_q <= '0;
      end else begin
         lvl_q  <= lvl;
         wlvl_q <= wlvl;
         stat_q <= (stat_q & ~clr) | edge_ev;   // new edge beats the clear
         if (we.en)   en_q   <= wmask;
         if (we.pol)  pol_q  <= wmask;
         if (we.wen)  wen_q  <= wmask;
         if (we.wpol) wpol_q <= wmask;
      end
   end
endmodule

// File: rtl/edge_irq_aggregator.sv
module edge_irq_aggregator
   import eic_pkg::*;
#(
   parameter int                BANK_W      = 32,
   parameter int                B0_USED     = 27,
   parameter int                B1_USED     = 23,
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_W      = 9,
   parameter logic [BANK_W-1:0] B1_POL_RST  = 32'h0006_0000
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [BANK_W+B1_USED-1:0]         src_in,
   input  logic [ADDR_W-1:0]                 reg_addr,
   input  logic                              reg_wr,
   input  logic [BANK_W-1:0]                 reg_wdata,
   output logic [BANK_W-1:0]                 reg_rdata,
   output logic                              irq_out,
   output logic                              wake_out
);
   localparam int NUM_SRC = BANK_W + B1_USED;
   localparam int NBANK   = 2;

   if (ADDR_W < 6 || B0_USED > BANK_W || B1_USED > BANK_W || B1_USED < 1) begin : g_bad_cfg
      $error("edge_irq_aggregator: bad parameter set");
   end

   logic [NUM_SRC-1:0] src_s;
   logic [BANK_W-1:0]  bank_src [NBANK];
   logic [BANK_W-1:0]  en_b [NBANK], pol_b [NBANK], stat_b [NBANK];
   logic [BANK_W-1:0]  wen_b [NBANK], wpol_b [NBANK];
   logic [BANK_W-1:0]  edge_b [NBANK], wake_b [NBANK], clr_b [NBANK];
   bank_we_t           we_b [NBANK];
   logic               in_win, bsel, clr_any, pend, wake_hit;
   rsel_e              rsel;

   eic_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(src_in), .dout(src_s)
   );

   assign bank_src[0] = src_s[BANK_W-1:0];
   assign bank_src[1] = BANK_W'(src_s[NUM_SRC-1:BANK_W]);

   assign in_win = (reg_addr[ADDR_W-1:6] == '0) && (reg_addr[1:0] == 2'b00);
   assign rsel   = rsel_e'(reg_addr[5:3]);
   assign bsel   = reg_addr[2];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int                U  = (b == 0) ? B0_USED : B1_USED;
      localparam logic [BANK_W-1:0] PR = (b == 0) ? {BANK_W{1'b0}} : B1_POL_RST;
      logic hit;
      assign hit = reg_wr && in_win && (bsel == 1'(b));
      assign we_b[b] = '{en:   hit && (rsel == RSEL_EN),
                         pol:  hit && (rsel == RSEL_POL),
                         stat: hit && (rsel == RSEL_STAT),
                         wen:  hit && (rsel == RSEL_WEN),
                         wpol: hit && (rsel == RSEL_WPOL)};
      eic_bank #(.BANK_W(BANK_W), .USED(U), .POL_RST(PR)) u_bank (
         .clk(clk), .rst_n(rst_n), .src_s(bank_src[b]), .we(we_b[b]),
         .wdata(reg_wdata), .en_q(en_b[b]), .pol_q(pol_b[b]),
         .stat_q(stat_b[b]), .wen_q(wen_b[b]), .wpol_q(wpol_b[b]),
         .edge_ev(edge_b[b]), .wake_ev(wake_b[b]), .clr(clr_b[b])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (in_win) begin
         case (rsel)
            RSEL_EN:   reg_rdata = en_b[bsel];
            RSEL_POL:  reg_rdata = pol_b[bsel];
            RSEL_STAT: reg_rdata = stat_b[bsel];
            RSEL_WEN:  reg_rdata = wen_b[bsel];
            RSEL_WPOL: reg_rdata = wpol_b[bsel];
            default:   reg_rdata = '0;
         endcase
      end
   end

   assign clr_any  = |(clr_b[0] | clr_b[1]);
   assign pend     = |(stat_b[0] & en_b[0]) | |(stat_b[1] & en_b[1]);
   assign wake_hit = |(wake_b[0] | wake_b[1]);

   // A clear gaps the request for one cycle so the host sees a fresh edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out  <= 1'b0;
         wake_out <= 1'b0;
      end else begin
         irq_out  <= pend && !clr_any;
         wake_out <= wake_hit;
      end
   end
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
   parameter int BANK_W  = 32,
   parameter int B0_USED = 27
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_out,
   input logic              wake_out,
   input logic              clr_any,
   input logic              pend,
   input logic              wake_hit,
   input logic              rd_stat0,
   input logic [BANK_W-1:0] reg_rdata,
   input logic [BANK_W-1:0] stat0,
   input logic [BANK_W-1:0] stat1,
   input logic [BANK_W-1:0] edge0,
   input logic [BANK_W-1:0] edge1,
   input logic [BANK_W-1:0] clr0,
   input logic [BANK_W-1:0] clr1
);
   localparam logic [BANK_W-1:0] PAD0 = ~BANK_W'((65'd1 << B0_USED) - 65'd1);

   AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      clr_any |=> !irq_out);                                        // R5
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(pend));                                     // R8
   AST_IRQ_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr_any) |=> irq_out);                              // R8
   AST_EDGE_WINS0: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge0) |=> ((stat0 & $past(edge0)) == $past(edge0)));       // R10
   AST_EDGE_WINS1: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge1) |=> ((stat1 & $past(edge1)) == $past(edge1)));       // R10
   AST_STAT_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat0) & ~stat0 & ~$past(clr0)) == '0));     // R4
   AST_STAT_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat1) & ~stat1 & ~$past(clr1)) == '0));     // R4
   AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_out |-> $past(wake_hit));                                // R9
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat0 |-> ((reg_rdata & PAD0) == '0));                     // R1
endmodule

bind edge_irq_aggregator eic_checker #(.BANK_W(BANK_W), .B0_USED(B0_USED)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .wake_out(wake_out),
   .clr_any(clr_any), .pend(pend), .wake_hit(wake_hit),
   .rd_stat0(in_win && (rsel == eic_pkg::RSEL_STAT) && !bsel),
   .reg_rdata(reg_rdata), .stat0(stat_b[0]), .stat1(stat_b[1]),
   .edge0(edge_b[0]), .edge1(edge_b[1]), .clr0(clr_b[0]), .clr1(clr_b[1])
);

// File: tb/edge_irq_aggregator_bench.sv
`timescale 1ns/1ps
module edge_irq_aggregator_bench;
   localparam logic [8:0] A_EN0 = 9'h00, A_EN1 = 9'h04, A_POL0 = 9'h08, A_POL1 = 9'h0C;
   localparam logic [8:0] A_ST0 = 9'h10, A_ST1 = 9'h14, A_WEN0 = 9'h18, A_WEN1 = 9'h1C;
   localparam logic [8:0] A_WPOL0 = 9'h20, A_WPOL1 = 9'h24;

   // {new src_in[54:0], expected bank0 status, expected bank1 status}
   // bank0 polarity 0x0000_00F0, bank1 polarity at its reset value
   localparam int NV = 9;
   localparam logic [118:0] VEC [NV] = '{
      {55'h00_0000_0000_0011, 32'h0000_0001, 32'h0000_0000},
      {55'h00_0000_0000_0010, 32'h0000_0000, 32'h0000_0000},
      {55'h00_0000_0000_0000, 32'h0000_0010, 32'h0000_0000},
      {55'h00_0000_FC00_0000, 32'h0400_0000, 32'h0000_0000},
      {55'h40_0001_0000_0000, 32'h0000_0000, 32'h0040_0001},
      {55'h46_0001_0000_0000, 32'h0000_0000, 32'h0000_0000},
      {55'h00_0000_0000_0000, 32'h0000_0000, 32'h0006_0000},
      {55'h7F_FFFF_FFFF_FFFF, 32'h07FF_FF0F, 32'h0079_FFFF},
      {55'h00_0000_0000_0000, 32'h0000_00F0, 32'h0006_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [54:0] src_in = '0;
   logic [8:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out, wake_out;
   int          vec_cnt = 0;
   int          err_cnt = 0;
   logic [31:0] rv;

   always #4 clk = ~clk;

   edge_irq_aggregator u_edge_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .wake_out(wake_out)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vec_cnt++;
      if (got !== exp) begin
         err_cnt++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   endtask

   initial begin
      #800000;
      err_cnt++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R7 reset state
      rd(A_EN0, rv);   chk("R7 en0", rv, 32'h0);
      rd(A_EN1, rv);   chk("R7 en1", rv, 32'h0);
      rd(A_POL0, rv);  chk("R7 pol0", rv, 32'h0);
      rd(A_POL1, rv);  chk("R7 pol1", rv, 32'h0006_0000);
      rd(A_WEN1, rv);  chk("R7 wen1", rv, 32'h0);
      rd(A_WPOL1, rv); chk("R7 wpol1", rv, 32'h0);
      rd(A_ST1, rv);   chk("R7 stat1 no spurious edge", rv, 32'h0);
      chk("R7 irq_out", {31'b0, irq_out}, 32'h0);
      chk("R7 wake_out", {31'b0, wake_out}, 32'h0);

      // table walk: R1 bank mapping, R3 polarity, R4 clear
      wr(A_POL0, 32'h0000_00F0);
      tick(4);
      wr(A_ST0, 32'hFFFF_FFFF);
      wr(A_ST1, 32'hFFFF_FFFF);
      for (int i = 0; i < NV; i++) begin
         src_in = VEC[i][118:64];
         tick(4);
         rd(A_ST0, rv); chk("R1/R3 stat0 vector", rv, VEC[i][63:32]);
         rd(A_ST1, rv); chk("R1/R3 stat1 vector", rv, VEC[i][31:0]);
         wr(A_ST0, 32'hFFFF_FFFF);
         wr(A_ST1, 32'hFFFF_FFFF);
         rd(A_ST0, rv); chk("R4 clear all bank0", rv, 32'h0);
      end
      wr(A_POL0, 32'h0);
      tick(3);
      rd(A_ST0, rv); chk("R3 polarity back to rising injects nothing", rv, 32'h0);

      // R8 status vs enable, R5 re-pulse, R4 write-zero
      wr(A_EN0, 32'h3);
      src_in[2:0] = 3'b111;
      tick(5);
      chk("R8 irq_out asserted", {31'b0, irq_out}, 32'h1);
      rd(A_ST0, rv); chk("R8 disabled source still latches", rv, 32'h7);
      wr(A_ST0, 32'h1);
      chk("R5 irq_out gap after clear", {31'b0, irq_out}, 32'h0);
      tick(1);
      chk("R5 irq_out reasserts", {31'b0, irq_out}, 32'h1);
      wr(A_ST0, 32'h0);
      tick(1);
      rd(A_ST0, rv); chk("R4 write zero keeps status", rv, 32'h6);
      chk("R4 write zero keeps irq_out", {31'b0, irq_out}, 32'h1);
      wr(A_ST0, 32'h2);
      tick(1);
      chk("R8 only disabled pending -> irq low", {31'b0, irq_out}, 32'h0);
      rd(A_ST0, rv); chk("R4 partial clear", rv, 32'h4);
      src_in[2:0] = 3'b000;
      tick(4);
      wr(A_ST0, 32'hFFFF_FFFF);

      // R6 polarity flip and restore with a quiet input
      wr(A_POL0, 32'h0000_0200);
      wr(A_POL0, 32'h0);
      tick(3);
      rd(A_ST0, rv); chk("R6 polarity toggle injects event", rv, 32'h0000_0200);
      wr(A_ST0, 32'hFFFF_FFFF);

      // R10 edge latched in the same cycle as its clear
      @(negedge clk);
      src_in[12] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      reg_addr = A_ST0; reg_wdata = 32'h0000_1000; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(A_ST0, rv); chk("R10 edge beats clear", rv, 32'h0000_1000);
      wr(A_ST0, 32'hFFFF_FFFF);

      // R9 wake path, independent of enable (bit 3 not enabled)
      wr(A_WEN0, 32'h0000_0008);
      @(negedge clk);
      src_in[3] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 wake pulse on rising", {31'b0, wake_out}, 32'h1);
      @(negedge clk);
      chk("R9 wake pulse one cycle", {31'b0, wake_out}, 32'h0);
      src_in[5] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 no wake without wake enable", {31'b0, wake_out}, 32'h0);
      wr(A_WPOL0, 32'h0000_0008);
      tick(3);
      @(negedge clk);
      src_in[3] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 wake on falling with wake polarity 1", {31'b0, wake_out}, 32'h1);
      wr(A_ST0, 32'hFFFF_FFFF);

      // R2 address map and R1 pad bits
      wr(A_EN1, 32'hFFFF_FFFF);
      rd(A_EN1, rv); chk("R1 bank1 pad bits masked", rv, 32'h007F_FFFF);
      rd(A_EN0, rv); chk("R2 bank1 write leaves bank0", rv, 32'h3);
      wr(9'h040, 32'hFFFF_FFFF);
      wr(9'h001, 32'hFFFF_FFFF);
      rd(A_EN0, rv); chk("R2 out-of-window writes ignored", rv, 32'h3);
      rd(9'h028, rv); chk("R2 unused offset reads zero", rv, 32'h0);
      rd(9'h002, rv); chk("R2 misaligned read zero", rv, 32'h0);
      rd(A_WPOL0, rv); chk("R2 wake polarity offset", rv, 32'h8);
      wr(A_EN1, 32'h0);

      summary();
   end
endmodule